// File: doc/BRIEF.md
# Fetch Stage Stall and Squash Controller

This block holds the front end of a five-stage in-order pipeline: the program counter, the register between fetch and decode, and the combinational logic that decides each cycle whether the front end advances, freezes or is squashed. The program counter addresses an external instruction memory. The word it returns is captured into the decode register together with the address it came from, so that a later stage can compute branch targets from that address.

Two conditions are handled. The first is a load sitting in execute whose destination register is read by the instruction in decode. For this the controller freezes the program counter and the decode register for one cycle and sends a bubble into the execute register. The second is a branch that execute has resolved as taken. For this the controller squashes both younger instructions and keeps fetching, starting from the branch target. When both conditions occur in the same cycle the branch takes precedence. The flush output for the execute register leaves the block and goes to that register.

Top module: `fetch_hazard_ctrl`

## Requirements
- R1: While reset is asserted, `pc` is set to RESET_PC (default 0) on a clock edge, `id_instr` and `id_pc` are 0, and with `ex_mem_read`=0 and `branch_taken`=0 the controls read `pc_write`=1, `ifid_write`=1, `ifid_flush`=0, `idex_flush`=0.
- R2: A load-use stall is present when `ex_mem_read`=1, `ex_rd` is nonzero, `ex_rd` equals either source field of `id_instr` (first source at bits 19:15, second at bits 24:20), and `branch_taken`=0. During a stall the outputs are `pc_write`=0, `ifid_write`=0, `idex_flush`=1 and `ifid_flush`=0.
- R3: When `ex_rd` is 0 no stall is raised, whatever the source fields hold.
- R4: When `ex_mem_read` is 0 no stall is raised, whatever the register numbers are.
- R5: When `branch_taken`=1 the outputs are `ifid_flush`=1, `idex_flush`=1, `pc_write`=1 and `ifid_write`=1.
- R6: On each clock edge with `pc_write`=1 and `branch_taken`=0, `pc` increases by PC_STEP (default 4). With `pc_write`=0, `pc` holds.
- R7: On each clock edge with `ifid_write`=1 and `ifid_flush`=0, the decode register captures `fetch_instr` and the current `pc`. With `ifid_write`=0 and `ifid_flush`=0, it holds.
- R8: A clock edge with `ifid_flush`=1 leaves `id_instr` and `id_pc` at 0. The all-zero word decodes as an instruction with no side effects.
- R9: Asserting `rst_n` low clears `id_instr` and `id_pc` at once, without waiting for a clock edge.
- R10: On a clock edge with `branch_taken`=1, `pc` loads `branch_target`. This also holds when a load-use condition is present in the same cycle, and in that case the decode register is zeroed rather than frozen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low reset |
| fetch_instr | input | IW | Instruction word read at `pc` |
| branch_taken | input | 1 | Execute stage resolved a branch as taken |
| branch_target | input | AW | Address of the taken branch target |
| ex_mem_read | input | 1 | Instruction in execute is a load |
| ex_rd | input | RW | Destination register of the instruction in execute |
| pc | output | AW | Current fetch address |
| id_instr | output | IW | Instruction held in the decode register |
| id_pc | output | AW | Fetch address of the instruction in decode |
| pc_write | output | 1 | Program counter update enable |
| ifid_write | output | 1 | Decode register load enable |
| ifid_flush | output | 1 | Decode register squash |
| idex_flush | output | 1 | Squash or bubble for the execute register |

## Verification
The checker verifies the following on every cycle. A frozen program counter or decode register stays unchanged. A free-running or redirected program counter reaches the right address. Every squash leaves zeros in the decode register. A branch always produces the two-slot flush without a freeze. A zero destination or a non-load never stalls. Only the bench scenarios can show that the stall triggers for the full range of destination and source register pairings, and that the branch takes precedence when it coincides with a load-use condition. The same applies to the ordering of a stall followed by release and to the decode register clearing mid-cycle on an asynchronous reset.

// File: rtl/fhc_pkg.sv
package fhc_pkg;

   // Source register field positions inside an instruction word
   localparam int unsigned SRC1_LSB = 15;
   localparam int unsigned SRC2_LSB = 20;

   // Front-end control bundle produced by the hazard decision logic
   typedef struct packed {
      logic pc_we;
      logic ifid_we;
      logic ifid_clr;
      logic idex_clr;
   } fhc_ctl_t;

endpackage

// File: rtl/fhc_detect.sv
module fhc_detect
   import fhc_pkg::*;
#(
   parameter int unsigned RW = 5
) (
   input  logic          ex_mem_read,
   input  logic [RW-1:0] ex_rd,
   input  logic [RW-1:0] id_src1,
   input  logic [RW-1:0] id_src2,
   input  logic          branch_taken,
   output fhc_ctl_t      ctl
);

   logic rd_live;
   logic rd_match;
   logic load_use;

   always_comb begin
      rd_live  = (ex_rd != '0);
      rd_match = (ex_rd == id_src1) || (ex_rd == id_src2);
      load_use = ex_mem_read && rd_live && rd_match;

      ctl = '{pc_we: 1'b1, ifid_we: 1'b1, ifid_clr: 1'b0, idex_clr: 1'b0};
      if (branch_taken) begin
         // redirect: squash both younger slots, keep fetching
         ctl.ifid_clr = 1'b1;
         ctl.idex_clr = 1'b1;
      end else if (load_use) begin
         // freeze front end, bubble into execute
         ctl.pc_we    = 1'b0;
         ctl.ifid_we  = 1'b0;
         ctl.idex_clr = 1'b1;
      end
   end

endmodule

// File: rtl/fhc_pc_reg.sv
module fhc_pc_reg #(
   parameter int unsigned AW         = 32,
   parameter int unsigned RESET_PC   = 0,
   parameter int unsigned PC_STEP    = 4,
   parameter bit          SYNC_RESET = 1'b1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          we,
   input  logic          redirect,
   input  logic [AW-1:0] target,
   output logic [AW-1:0] pc
);

   localparam logic [AW-1:0] PC_INIT = AW'(RESET_PC);
   localparam logic [AW-1:0] STEP    = AW'(PC_STEP);

   logic [AW-1:0] pc_q;
   logic [AW-1:0] pc_nxt;

   assign pc_nxt = redirect ? target : (pc_q + STEP);

   generate
      if (SYNC_RESET) begin : g_sync
         always_ff @(posedge clk) begin
            if (!rst_n)  pc_q <= PC_INIT;
            else if (we) pc_q <= pc_nxt;
         end
      end else begin : g_async
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)  pc_q <= PC_INIT;
            else if (we) pc_q <= pc_nxt;
         end
      end
   endgenerate

   assign pc = pc_q;

endmodule

// File: rtl/fhc_ifid_reg.sv
module fhc_ifid_reg #(
   parameter int unsigned AW = 32,
   parameter int unsigned IW = 32
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          we,
   input  logic          clr,
   input  logic [IW-1:0] instr_in,
   input  logic [AW-1:0] pc_in,
   output logic [IW-1:0] instr_out,
   output logic [AW-1:0] pc_out
);

   logic [IW-1:0] instr_q;
   logic [AW-1:0] pc_q;

   // squash outranks a held write-enable
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         instr_q <= '0;
         pc_q    <= '0;
      end else if (clr) begin
         instr_q <= '0;
         pc_q    <= '0;
      end else if (we) begin
         instr_q <= instr_in;
         pc_q    <= pc_in;
      end
   end

   assign instr_out = instr_q;
   assign pc_out    = pc_q;

endmodule

// File: rtl/fetch_hazard_ctrl.sv
module fetch_hazard_ctrl
   import fhc_pkg::*;
#(
   parameter int unsigned AW            = 32,
   parameter int unsigned IW            = 32,
   parameter int unsigned RW            = 5,
   parameter int unsigned RESET_PC      = 0,
   parameter int unsigned PC_STEP       = 4,
   parameter bit          PC_SYNC_RESET = 1'b1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [IW-1:0] fetch_instr,
   input  logic          branch_taken,
   input  logic [AW-1:0] branch_target,
   input  logic          ex_mem_read,
   input  logic [RW-1:0] ex_rd,
   output logic [AW-1:0] pc,
   output logic [IW-1:0] id_instr,
   output logic [AW-1:0] id_pc,
   output logic          pc_write,
   output logic          ifid_write,
   output logic          ifid_flush,
   output logic          idex_flush
);

   generate
      if (SRC2_LSB + RW > IW) begin : g_bad_fields
         $error("source register fields do not fit in the instruction width");
      end
      if (AW < 3) begin : g_bad_aw
         $error("address width too small");
      end
      if (PC_STEP == 0) begin : g_bad_step
         $error("program counter step must be nonzero");
      end
   endgenerate

   fhc_ctl_t      ctl;
   logic [RW-1:0] id_src1;
   logic [RW-1:0] id_src2;

   assign id_src1 = id_instr[SRC1_LSB +: RW];
   assign id_src2 = id_instr[SRC2_LSB +: RW];

   fhc_detect #(.RW(RW)) u_detect (
      .ex_mem_read (ex_mem_read),
      .ex_rd       (ex_rd),
      .id_src1     (id_src1),
      .id_src2     (id_src2),
      .branch_taken(branch_taken),
      .ctl         (ctl)
   );

   fhc_pc_reg #(
      .AW        (AW),
      .RESET_PC  (RESET_PC),
      .PC_STEP   (PC_STEP),
      .SYNC_RESET(PC_SYNC_RESET)
   ) u_pc (
      .clk     (clk),
      .rst_n   (rst_n),
      .we      (ctl.pc_we),
      .redirect(branch_taken),
      .target  (branch_target),
      .pc      (pc)
   );

   fhc_ifid_reg #(.AW(AW), .IW(IW)) u_ifid (
      .clk      (clk),
      .rst_n    (rst_n),
      .we       (ctl.ifid_we),
      .clr      (ctl.ifid_clr),
      .instr_in (fetch_instr),
      .pc_in    (pc),
      .instr_out(id_instr),
      .pc_out   (id_pc)
   );

   assign pc_write   = ctl.pc_we;
   assign ifid_write = ctl.ifid_we;
   assign ifid_flush = ctl.ifid_clr;
   assign idex_flush = ctl.idex_clr;

endmodule

// File: rtl/fhc_checker.sv
module fhc_checker #(
   parameter int unsigned AW      = 32,
   parameter int unsigned IW      = 32,
   parameter int unsigned RW      = 5,
   parameter int unsigned PC_STEP = 4
) (
   input logic          clk,
   input logic          rst_n,
   input logic          branch_taken,
   input logic [AW-1:0] branch_target,
   input logic          ex_mem_read,
   input logic [RW-1:0] ex_rd,
   input logic [AW-1:0] pc,
   input logic [IW-1:0] id_instr,
   input logic [AW-1:0] id_pc,
   input logic          pc_write,
   input logic          ifid_write,
   input logic          ifid_flush,
   input logic          idex_flush
);

   localparam logic [AW-1:0] STEP = AW'(PC_STEP);

   assert_stall_shape_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !pc_write |-> (!ifid_write && idex_flush && !ifid_flush));

   assert_rd0_no_stall_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (ex_rd == '0 && !branch_taken) |-> (pc_write && ifid_write && !idex_flush));

   assert_nonload_no_stall_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (!ex_mem_read && !branch_taken) |-> (pc_write && ifid_write && !idex_flush));

   assert_branch_squash_R5: assert property (@(posedge clk) disable iff (!rst_n)
      branch_taken |-> (ifid_flush && idex_flush && pc_write && ifid_write));

   assert_pc_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (pc_write && !branch_taken) |=> (pc == $past(pc) + STEP));

   assert_pc_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
      !pc_write |=> $stable(pc));

   assert_ifid_capture_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (ifid_write && !ifid_flush) |=> (id_pc == $past(pc)));

   assert_ifid_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (!ifid_write && !ifid_flush) |=> ($stable(id_instr) && $stable(id_pc)));

   assert_ifid_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
      ifid_flush |=> (id_instr == '0 && id_pc == '0));

   assert_redirect_R10: assert property (@(posedge clk) disable iff (!rst_n)
      branch_taken |=> (pc == $past(branch_target)));

endmodule

bind fetch_hazard_ctrl fhc_checker #(
   .AW(AW), .IW(IW), .RW(RW), .PC_STEP(PC_STEP)
) u_fhc_checker (
   .clk          (clk),
   .rst_n        (rst_n),
   .branch_taken (branch_taken),
   .branch_target(branch_target),
   .ex_mem_read  (ex_mem_read),
   .ex_rd        (ex_rd),
   .pc           (pc),
   .id_instr     (id_instr),
   .id_pc        (id_pc),
   .pc_write     (pc_write),
   .ifid_write   (ifid_write),
   .ifid_flush   (ifid_flush),
   .idex_flush   (idex_flush)
);

// File: tb/fetch_hazard_ctrl_test.sv
`timescale 1ns/1ps
module fetch_hazard_ctrl_test;

   localparam int AW = 32;
   localparam int IW = 32;
   localparam int RW = 5;

   logic          clk = 1'b0;
   logic          clk_en = 1'b1;
   logic          rst_n = 1'b0;
   logic [IW-1:0] fetch_instr = '0;
   logic          branch_taken = 1'b0;
   logic [AW-1:0] branch_target = '0;
   logic          ex_mem_read = 1'b0;
   logic [RW-1:0] ex_rd = '0;
   logic [AW-1:0] pc;
   logic [IW-1:0] id_instr;
   logic [AW-1:0] id_pc;
   logic          pc_write, ifid_write, ifid_flush, idex_flush;

   int checks = 0;
   int failures = 0;
   bit done = 1'b0;

   logic [AW-1:0] e_pc;
   logic [IW-1:0] e_instr;
   logic [AW-1:0] e_idpc;

   fetch_hazard_ctrl uut (
      .clk(clk), .rst_n(rst_n), .fetch_instr(fetch_instr),
      .branch_taken(branch_taken), .branch_target(branch_target),
      .ex_mem_read(ex_mem_read), .ex_rd(ex_rd), .pc(pc),
      .id_instr(id_instr), .id_pc(id_pc), .pc_write(pc_write),
      .ifid_write(ifid_write), .ifid_flush(ifid_flush), .idex_flush(idex_flush)
   );

   always begin
      #2;
      if (clk_en) clk = ~clk;
   end

   task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   function automatic logic [IW-1:0] mk(input int s1, input int s2, input int salt);
      return {7'b0100000, 5'(s2), 5'(s1), 3'(salt), 5'(salt + 3), 7'b0110011};
   endfunction

   function automatic logic [3:0] exp_ctl(input logic [IW-1:0] ins, input logic mr,
                                          input logic [RW-1:0] rd, input logic br);
      logic stall;
      stall = mr && rd != 0 && (rd == ins[19:15] || rd == ins[24:20]);
      if (br) return 4'b1111;        // {pc_write, ifid_write, ifid_flush, idex_flush}
      if (stall) return 4'b0001;
      return 4'b1100;
   endfunction

   // model the edge from current inputs, clock it, compare state
   task automatic step(input string tag);
      logic [3:0] c;
      c = exp_ctl(e_instr, ex_mem_read, ex_rd, branch_taken);
      if (branch_taken) begin
         e_pc = branch_target; e_instr = '0; e_idpc = '0;
      end else if (c[3]) begin
         e_instr = fetch_instr; e_idpc = e_pc; e_pc = e_pc + 4;
      end
      @(posedge clk); #1;
      check({tag, " pc"}, 64'(pc), 64'(e_pc));
      check({tag, " id_instr"}, 64'(id_instr), 64'(e_instr));
      check({tag, " id_pc"}, 64'(id_pc), 64'(e_idpc));
   endtask

   task automatic idle();
      branch_taken = 0; ex_mem_read = 0; ex_rd = '0;
   endtask

   initial begin
      #700000;
      if (!done) begin
         failures++; checks++;
         $display("FAIL watchdog expired");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      // R1 reset state
      repeat (3) @(posedge clk);
      #1;
      check("R1 pc", 64'(pc), 0);
      check("R1 id_instr", 64'(id_instr), 0);
      check("R1 id_pc", 64'(id_pc), 0);
      check("R1 ctl", 64'({pc_write, ifid_write, ifid_flush, idex_flush}), 64'(4'b1100));
      rst_n = 1'b1;
      e_pc = '0; e_instr = '0; e_idpc = '0;

      // R6 R7 free run
      for (int i = 0; i < 10; i++) begin
         fetch_instr = mk(i, i + 1, i);
         step("R6 R7 freerun");
      end

      // R2 stall: hold PC and decode register for the stall cycle
      fetch_instr = mk(7, 2, 1);
      step("R7 load");
      fetch_instr = mk(9, 9, 2);
      ex_mem_read = 1; ex_rd = 5'd7;
      #0.5;
      check("R2 ctl src1", 64'({pc_write, ifid_write, ifid_flush, idex_flush}), 64'(4'b0001));
      step("R2 R6 stall hold");
      idle();
      step("R2 release");
      // second source field match
      fetch_instr = mk(1, 12, 3);
      step("R7 load");
      ex_mem_read = 1; ex_rd = 5'd12;
      step("R2 src2 stall");
      idle();

      // R5 R8 branch squash
      branch_target = 32'h0000_0200;
      branch_taken = 1;
      #0.5;
      check("R5 ctl", 64'({pc_write, ifid_write, ifid_flush, idex_flush}), 64'(4'b1111));
      step("R5 R8 branch");
      idle();
      fetch_instr = mk(4, 6, 5);
      step("R6 after branch");
      check("R6 id_pc after branch", 64'(id_pc), 64'h200);

      // R10 branch and load-use in same cycle
      fetch_instr = mk(6, 6, 6);
      step("R7 load");
      ex_mem_read = 1; ex_rd = 5'd6; branch_taken = 1; branch_target = 32'h0000_1000;
      #0.5;
      check("R10 ctl", 64'({pc_write, ifid_write, ifid_flush, idex_flush}), 64'(4'b1111));
      step("R10 branch wins");
      idle();
      step("R10 resume");

      // R2 R3 R4 R5 near-exhaustive decision sweep
      for (int a = 0; a < 32; a++) begin
         for (int b = 0; b < 32; b++) begin
            fetch_instr = mk(a, b, a + b);
            step("R7 sweep load");
            clk_en = 0;
            for (int rd = 0; rd < 32; rd++) begin
               for (int m = 0; m < 4; m++) begin
                  ex_rd = 5'(rd); ex_mem_read = m[0]; branch_taken = m[1];
                  #0.2;
                  check(rd == 0 ? "R3 sweep" : (m[0] == 0 ? "R4 sweep" : (m[1] ? "R5 sweep" : "R2 sweep")),
                        64'({pc_write, ifid_write, ifid_flush, idex_flush}),
                        64'(exp_ctl(e_instr, m[0], 5'(rd), m[1])));
               end
            end
            idle();
            #0.2;
            clk_en = 1;
         end
      end

      // R9 asynchronous clear of the decode register
      fetch_instr = mk(3, 5, 7);
      step("R7 load");
      rst_n = 0;
      #0.5;
      check("R9 id_instr", 64'(id_instr), 0);
      check("R9 id_pc", 64'(id_pc), 0);
      @(posedge clk); #1;
      check("R1 pc in reset", 64'(pc), 0);
      rst_n = 1;
      e_pc = '0; e_instr = '0; e_idpc = '0;
      fetch_instr = mk(2, 2, 2);
      step("R1 R6 after reset");

      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

endmodule